// File: doc/BRIEF.md
# Standby Mode Clock Gating Controller

This block sits in a small system controller and decides which clock enables stay active while the system is idle. When the block is running, a halt request moves it into one of two halt depths, chosen by a mode-select bit. A sleep request moves it into the deepest state. Each depth has its own set of stopped clocks. The block drives enables for the CPU, the bus control unit, the DMA engine, a group of peripherals, the high-speed oscillator and the low-speed oscillator.

When the block enters any standby depth, it captures the peripheral and oscillator settings that are in force at that moment. Each depth also has its own rules for which wake sources it accepts. NMI wakes every depth. The accepted interrupts are narrowed as the depth increases, according to which clocks are still alive. A qualified wake produces a one-cycle wake pulse. During that cycle the high-speed oscillator enable is already restored. All other enables return to their running values one cycle later.

Top module: `standby_clkctl`

## Requirements
- R1: While `rst` is high, the block is in the running state. `cpu_ce`, `bcu_ce` and `dma_ce` are 1, `wake_pulse` is 0, and the peripheral and oscillator enables follow their setting inputs.
- R2: While running, `cpu_ce`, `bcu_ce` and `dma_ce` are 1. `per_ce` equals `per_en_cfg`, `hosc_ce` equals `hosc_cfg` and `losc_ce` equals `losc_cfg`, combinationally.
- R3: `halt_req` with `halt_deep`=0, sampled while running, enters basic halt on the next edge. In basic halt, `cpu_ce`=0, `bcu_ce`=1 and `dma_ce`=1. The peripheral and both oscillator enables hold the values captured at entry.
- R4: `halt_req` with `halt_deep`=1 enters deep halt. In deep halt, `cpu_ce`, `bcu_ce` and `dma_ce` are all 0. The peripheral and both oscillator enables hold the values captured at entry.
- R5: `sleep_req` enters sleep and takes priority over `halt_req` in the same cycle. In sleep, `cpu_ce`, `bcu_ce`, `dma_ce`, every `per_ce` bit and `hosc_ce` are 0. `losc_ce` holds its captured value.
- R6: `nmi` high in any standby depth produces `wake_pulse` on the next edge.
- R7: In basic halt, any interrupt wakes the block: any bit of `irq_per`, `irq_port` or `irq_ctimer`.
- R8: In deep halt, `irq_port` and `irq_ctimer` wake the block. A bit `irq_per[i]` wakes it only if bit i of the captured peripheral enables is 1.
- R9: In sleep, `irq_port` wakes the block. `irq_ctimer` wakes it only if the captured low-speed oscillator enable is 1. `irq_per` never wakes it.
- R10: `wake_pulse` lasts exactly one cycle. In that cycle, `hosc_ce` already equals the captured high-speed value and `cpu_ce` is still 0. On the next edge the block is running again.
- R11: A standby request is ignored while running if `nmi` or any interrupt input is high in that cycle. A request is also ignored in the wake-pulse cycle.
- R12: While in standby, changes to `per_en_cfg`, `hosc_cfg` and `losc_cfg` do not affect any enable output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Request to enter a halt depth |
| halt_deep | input | 1 | Halt depth select: 0 basic, 1 deep |
| sleep_req | input | 1 | Request to enter sleep |
| nmi | input | 1 | Non-maskable interrupt |
| irq_per | input | NPER | Unmasked peripheral interrupts, one per peripheral |
| irq_port | input | 1 | Unmasked input-port interrupt |
| irq_ctimer | input | 1 | Unmasked clock-timer interrupt |
| per_en_cfg | input | NPER | Peripheral clock run settings |
| hosc_cfg | input | 1 | High-speed oscillator run setting |
| losc_cfg | input | 1 | Low-speed oscillator run setting |
| cpu_ce | output | 1 | CPU clock enable |
| bcu_ce | output | 1 | Bus control unit clock enable |
| dma_ce | output | 1 | DMA clock enable |
| per_ce | output | NPER | Peripheral clock enables |
| hosc_ce | output | 1 | High-speed oscillator enable |
| losc_ce | output | 1 | Low-speed oscillator enable |
| wake_pulse | output | 1 | One-cycle wake indication |

## Verification
Outputs in the running state depend on the setting inputs in the same cycle, with no register delay. Every standby transition appears one edge after the request or wake source is sampled. The return to running comes one edge after the wake pulse. The bench samples one nanosecond after each rising edge and only then changes inputs, so each comparison reflects exactly the edge just taken. A behavioural model, advanced on the same edge, predicts the whole output vector for every cycle. Directed checks sample the one-cycle windows in which a wake source must or must not be seen.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_HALT  = 3'd1,
        ST_HALT2 = 3'd2,
        ST_SLEEP = 3'd3,
        ST_WAKE  = 3'd4
    } stby_st_e;

    typedef struct packed {
        logic cpu;
        logic bcu;
        logic dma;
        logic hosc;
        logic losc;
    } core_en_t;

    function automatic logic is_standby(stby_st_e s);
        return (s == ST_HALT) || (s == ST_HALT2) || (s == ST_SLEEP);
    endfunction

    // sleep outranks halt; the mode bit picks the halt depth
    function automatic stby_st_e pick_entry(logic halt_req, logic halt_deep,
                                            logic sleep_req);
        if (sleep_req)
            return ST_SLEEP;
        else if (halt_req)
            return halt_deep ? ST_HALT2 : ST_HALT;
        else
            return ST_RUN;
    endfunction

endpackage

// File: rtl/stby_wake_qual.sv
module stby_wake_qual
    import stby_pkg::*;
#(
    parameter int NPER = 4
) (
    input  stby_st_e          mode,
    input  logic              nmi,
    input  logic [NPER-1:0]   irq_per,
    input  logic              irq_port,
    input  logic              irq_ctimer,
    input  logic [NPER-1:0]   per_snap,
    input  logic              losc_snap,
    output logic              wake_hit
);

    logic per_any;
    logic per_live;

    assign per_any  = |irq_per;
    assign per_live = |(irq_per & per_snap);

    always_comb begin
        unique case (mode)
            ST_HALT:  wake_hit = nmi | per_any | irq_port | irq_ctimer;
            ST_HALT2: wake_hit = nmi | per_live | irq_port | irq_ctimer;
            ST_SLEEP: wake_hit = nmi | irq_port | (irq_ctimer & losc_snap);
            default:  wake_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/stby_gate_map.sv
module stby_gate_map
    import stby_pkg::*;
#(
    parameter int NPER = 4
) (
    input  stby_st_e          view,
    input  logic              waking,
    input  logic [NPER-1:0]   per_live,
    input  logic              hosc_live,
    input  logic              losc_live,
    input  logic [NPER-1:0]   per_snap,
    input  logic              hosc_snap,
    input  logic              losc_snap,
    output core_en_t          en,
    output logic [NPER-1:0]   per_ce
);

    localparam logic [NPER-1:0] PER_OFF = '0;

    always_comb begin
        en     = '{cpu: 1'b1, bcu: 1'b1, dma: 1'b1, hosc: hosc_live, losc: losc_live};
        per_ce = per_live;
        unique case (view)
            ST_HALT: begin
                en     = '{cpu: 1'b0, bcu: 1'b1, dma: 1'b1, hosc: hosc_snap, losc: losc_snap};
                per_ce = per_snap;
            end
            ST_HALT2: begin
                en     = '{cpu: 1'b0, bcu: 1'b0, dma: 1'b0, hosc: hosc_snap, losc: losc_snap};
                per_ce = per_snap;
            end
            ST_SLEEP: begin
                en     = '{cpu: 1'b0, bcu: 1'b0, dma: 1'b0, hosc: 1'b0, losc: losc_snap};
                per_ce = PER_OFF;
            end
            default: ;
        endcase
        // fast oscillator comes back one cycle ahead of everything else
        if (waking)
            en.hosc = hosc_snap;
    end

endmodule

// File: rtl/standby_clkctl.sv
module standby_clkctl
    import stby_pkg::*;
#(
    parameter int NPER = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt_req,
    input  logic              halt_deep,
    input  logic              sleep_req,
    input  logic              nmi,
    input  logic [NPER-1:0]   irq_per,
    input  logic              irq_port,
    input  logic              irq_ctimer,
    input  logic [NPER-1:0]   per_en_cfg,
    input  logic              hosc_cfg,
    input  logic              losc_cfg,
    output logic              cpu_ce,
    output logic              bcu_ce,
    output logic              dma_ce,
    output logic [NPER-1:0]   per_ce,
    output logic              hosc_ce,
    output logic              losc_ce,
    output logic              wake_pulse
);

    stby_st_e        state_q;
    stby_st_e        mode_q;
    stby_st_e        entry;
    stby_st_e        view;
    logic [NPER-1:0] per_snap_q;
    logic            hosc_snap_q;
    logic            losc_snap_q;
    logic            pending;
    logic            wake_hit;
    logic            waking;
    core_en_t        en;

    assign pending = nmi | (|irq_per) | irq_port | irq_ctimer;
    assign entry   = pick_entry(halt_req, halt_deep, sleep_req);
    assign waking  = (state_q == ST_WAKE);
    assign view    = waking ? mode_q : state_q;

    stby_wake_qual #(.NPER(NPER)) u_qual (
        .mode       (state_q),
        .nmi        (nmi),
        .irq_per    (irq_per),
        .irq_port   (irq_port),
        .irq_ctimer (irq_ctimer),
        .per_snap   (per_snap_q),
        .losc_snap  (losc_snap_q),
        .wake_hit   (wake_hit)
    );

    stby_gate_map #(.NPER(NPER)) u_map (
        .view       (view),
        .waking     (waking),
        .per_live   (per_en_cfg),
        .hosc_live  (hosc_cfg),
        .losc_live  (losc_cfg),
        .per_snap   (per_snap_q),
        .hosc_snap  (hosc_snap_q),
        .losc_snap  (losc_snap_q),
        .en         (en),
        .per_ce     (per_ce)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_RUN;
            mode_q      <= ST_RUN;
            per_snap_q  <= '0;
            hosc_snap_q <= 1'b0;
            losc_snap_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (!pending && entry != ST_RUN) begin
                        state_q     <= entry;
                        mode_q      <= entry;
                        per_snap_q  <= per_en_cfg;
                        hosc_snap_q <= hosc_cfg;
                        losc_snap_q <= losc_cfg;
                    end
                end
                ST_HALT, ST_HALT2, ST_SLEEP: begin
                    if (wake_hit)
                        state_q <= ST_WAKE;
                end
                default: begin
                    state_q <= ST_RUN;
                    mode_q  <= ST_RUN;
                end
            endcase
        end
    end

    assign cpu_ce     = en.cpu;
    assign bcu_ce     = en.bcu;
    assign dma_ce     = en.dma;
    assign hosc_ce    = en.hosc;
    assign losc_ce    = en.losc;
    assign wake_pulse = waking;

endmodule

// File: rtl/stby_clkctl_chk.sv
module stby_clkctl_chk
    import stby_pkg::*;
#(
    parameter int NPER = 4
) (
    input logic              clk,
    input logic              rst,
    input stby_st_e          state_q,
    input logic              nmi,
    input logic [NPER-1:0]   per_en_cfg,
    input logic              cpu_ce,
    input logic              bcu_ce,
    input logic              dma_ce,
    input logic [NPER-1:0]   per_ce,
    input logic              hosc_ce,
    input logic              wake_pulse
);

    // R2
    run_gates_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_RUN |-> cpu_ce && bcu_ce && dma_ce && per_ce == per_en_cfg);

    // R3
    halt_gates_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_HALT |-> !cpu_ce && bcu_ce && dma_ce);

    // R4
    halt2_gates_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_HALT2 |-> !cpu_ce && !bcu_ce && !dma_ce);

    // R5
    sleep_gates_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_SLEEP |-> !cpu_ce && !bcu_ce && !dma_ce && !hosc_ce && per_ce == '0);

    // R6
    nmi_wake_chk: assert property (@(posedge clk) disable iff (rst)
        is_standby(state_q) && nmi |=> wake_pulse);

    // R10
    wake_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse && cpu_ce);

    // R11
    pend_block_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_RUN && nmi |=> state_q == ST_RUN);

endmodule

bind standby_clkctl stby_clkctl_chk #(.NPER(NPER)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .state_q    (state_q),
    .nmi        (nmi),
    .per_en_cfg (per_en_cfg),
    .cpu_ce     (cpu_ce),
    .bcu_ce     (bcu_ce),
    .dma_ce     (dma_ce),
    .per_ce     (per_ce),
    .hosc_ce    (hosc_ce),
    .wake_pulse (wake_pulse)
);

// File: tb/sim_standby_clkctl.sv
`timescale 1ns/100ps
module sim_standby_clkctl;

    localparam int NPER = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt_req = 0, halt_deep = 0, sleep_req = 0, nmi = 0;
    logic [NPER-1:0] irq_per = '0;
    logic irq_port = 0, irq_ctimer = 0;
    logic [NPER-1:0] per_en_cfg = 4'b1010;
    logic hosc_cfg = 1, losc_cfg = 1;
    logic cpu_ce, bcu_ce, dma_ce, hosc_ce, losc_ce, wake_pulse;
    logic [NPER-1:0] per_ce;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    // model: 0 run, 1 basic halt, 2 deep halt, 3 sleep, 4 wake cycle
    int ms = 0, mm = 0;
    logic [NPER-1:0] sp = '0;
    logic sh = 0, sl = 0;

    always #2.5 clk = ~clk;

    standby_clkctl #(.NPER(NPER)) u0 (
        .clk(clk), .rst(rst), .halt_req(halt_req), .halt_deep(halt_deep),
        .sleep_req(sleep_req), .nmi(nmi), .irq_per(irq_per), .irq_port(irq_port),
        .irq_ctimer(irq_ctimer), .per_en_cfg(per_en_cfg), .hosc_cfg(hosc_cfg),
        .losc_cfg(losc_cfg), .cpu_ce(cpu_ce), .bcu_ce(bcu_ce), .dma_ce(dma_ce),
        .per_ce(per_ce), .hosc_ce(hosc_ce), .losc_ce(losc_ce), .wake_pulse(wake_pulse)
    );

    always @(posedge clk) begin
        int req;
        logic woke;
        if (rst) begin
            ms = 0; mm = 0;
        end else if (ms == 0) begin
            req = 0;
            if (sleep_req) req = 3;
            else if (halt_req) req = halt_deep ? 2 : 1;
            if (req != 0 && !(nmi || irq_per != 0 || irq_port || irq_ctimer)) begin
                ms = req; mm = req; sp = per_en_cfg; sh = hosc_cfg; sl = losc_cfg;
            end
        end else if (ms == 4) begin
            ms = 0; mm = 0;
        end else begin
            woke = nmi || irq_port;
            if (ms == 1) woke = woke || irq_ctimer || irq_per != 0;
            if (ms == 2) woke = woke || irq_ctimer || (irq_per & sp) != 0;
            if (ms == 3) woke = woke || (irq_ctimer && sl);
            if (woke) ms = 4;
        end
    end

    // {cpu, bcu, dma, per, hosc, losc, wake}
    function automatic logic [NPER+5:0] expect_vec();
        int v;
        logic c, b, d, h, l;
        logic [NPER-1:0] p;
        v = (ms == 4) ? mm : ms;
        case (v)
            1: begin c = 0; b = 1; d = 1; p = sp; h = sh; l = sl; end
            2: begin c = 0; b = 0; d = 0; p = sp; h = sh; l = sl; end
            3: begin c = 0; b = 0; d = 0; p = '0; h = 0; l = sl; end
            default: begin c = 1; b = 1; d = 1; p = per_en_cfg; h = hosc_cfg; l = losc_cfg; end
        endcase
        if (ms == 4) h = sh;
        return {c, b, d, p, h, l, ms == 4};
    endfunction

    function automatic string state_tag();
        case (ms)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R10";
            default: return rst ? "R1" : "R2";
        endcase
    endfunction

    task automatic chk(string tag, logic [NPER-1:0] act, logic [NPER-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        logic [NPER+5:0] act, exp;
        @(posedge clk);
        #1;
        act = {cpu_ce, bcu_ce, dma_ce, per_ce, hosc_ce, losc_ce, wake_pulse};
        exp = expect_vec();
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b (t=%0t)", state_tag(), act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        tick();
        // R1 reset state
        chk("R1", {cpu_ce, bcu_ce, dma_ce, wake_pulse}, 4'b1110);
        chk("R1", per_ce, 4'b1010);
        rst = 0;
        tick();
        // R2 live follow
        per_en_cfg = 4'b0110;
        tick();
        chk("R2", per_ce, 4'b0110);

        // R3 basic halt
        halt_req = 1; halt_deep = 0;
        tick();
        halt_req = 0;
        chk("R3", {cpu_ce, bcu_ce, dma_ce}, 3'b011);
        // R12 settings change ignored in standby
        per_en_cfg = 4'b1111; hosc_cfg = 0;
        tick();
        chk("R12", per_ce, 4'b0110);
        chk("R12", hosc_ce, 1'b1);
        // R7 any peripheral interrupt wakes basic halt
        irq_per = 4'b0001;
        tick();
        irq_per = '0;
        chk("R7", wake_pulse, 1'b1);
        chk("R10", {hosc_ce, cpu_ce}, 2'b10);
        tick();
        chk("R10", {cpu_ce, wake_pulse}, 2'b10);
        chk("R2", per_ce, 4'b1111);

        // R4 deep halt, R8 qualification
        per_en_cfg = 4'b0110; hosc_cfg = 1;
        halt_req = 1; halt_deep = 1;
        tick();
        halt_req = 0;
        chk("R4", {cpu_ce, bcu_ce, dma_ce}, 3'b000);
        irq_per = 4'b0001;
        tick();
        chk("R8", wake_pulse, 1'b0);
        tick();
        chk("R8", wake_pulse, 1'b0);
        irq_per = 4'b0010;
        tick();
        irq_per = '0;
        chk("R8", wake_pulse, 1'b1);
        tick();

        // R5 sleep wins over halt; R9 qualification
        losc_cfg = 0;
        sleep_req = 1; halt_req = 1; halt_deep = 0;
        tick();
        sleep_req = 0; halt_req = 0;
        chk("R5", {bcu_ce, dma_ce, hosc_ce, losc_ce}, 4'b0000);
        chk("R5", per_ce, 4'b0000);
        irq_ctimer = 1;
        tick();
        irq_ctimer = 0;
        chk("R9", wake_pulse, 1'b0);
        irq_per = 4'b1111;
        tick();
        irq_per = '0;
        chk("R9", wake_pulse, 1'b0);
        irq_port = 1;
        tick();
        irq_port = 0;
        chk("R9", wake_pulse, 1'b1);
        chk("R10", {hosc_ce, cpu_ce}, 2'b10);
        tick();
        losc_cfg = 1;
        sleep_req = 1;
        tick();
        sleep_req = 0;
        chk("R5", losc_ce, 1'b1);
        irq_ctimer = 1;
        tick();
        irq_ctimer = 0;
        chk("R9", wake_pulse, 1'b1);
        tick();

        // R6 NMI from deep halt and from sleep
        halt_req = 1; halt_deep = 1;
        tick();
        halt_req = 0;
        nmi = 1;
        tick();
        nmi = 0;
        chk("R6", wake_pulse, 1'b1);
        tick();
        sleep_req = 1;
        tick();
        sleep_req = 0;
        nmi = 1;
        tick();
        nmi = 0;
        chk("R6", wake_pulse, 1'b1);
        // R11 request in wake cycle ignored
        halt_req = 1; halt_deep = 0;
        tick();
        halt_req = 0;
        chk("R11", cpu_ce, 1'b1);
        tick();
        chk("R11", cpu_ce, 1'b1);

        // R11 pending wake blocks entry
        nmi = 1; halt_req = 1;
        tick();
        nmi = 0; halt_req = 0;
        chk("R11", cpu_ce, 1'b1);
        irq_port = 1; sleep_req = 1;
        tick();
        irq_port = 0; sleep_req = 0;
        chk("R11", {cpu_ce, hosc_ce}, 2'b11);
        tick();

        // mixed traffic against the model
        for (int i = 0; i < 2000; i++) begin
            halt_req   = ($urandom % 6) == 0;
            halt_deep  = $urandom % 2;
            sleep_req  = ($urandom % 10) == 0;
            nmi        = ($urandom % 40) == 0;
            irq_per    = (($urandom % 5) == 0) ? NPER'($urandom) : '0;
            irq_port   = ($urandom % 15) == 0;
            irq_ctimer = ($urandom % 12) == 0;
            if (($urandom % 8) == 0) per_en_cfg = NPER'($urandom);
            hosc_cfg   = ($urandom % 8) != 0;
            losc_cfg   = $urandom % 2;
            rst        = ($urandom % 500) == 0;
            tick();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule